// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Unit

This unit gathers the event pulses of one DMA channel into a sticky 12-bit status word and drives a single level interrupt toward the system. Software reaches it through a 32-bit register port that moves whole words only. It addresses registers by word index. Status bits are cleared by writing ones to them. The mask cannot be written directly: software lowers mask bits through an unmask strobe register and raises them through a mask-set strobe register. Both strobe registers read back as zero.

Two 8-bit accounting counters count completed descriptors that asked for an interrupt, one for the source side and one for the destination side. Reading a counter returns its value and clears it. A counter that wraps raises its own overflow status bit. An access to a word index that holds no register raises a dedicated status bit, reads as zero and changes nothing.

Word index map: 0 status, 1 mask (read only), 2 unmask strobe, 3 mask-set strobe, 4 source counter, 5 destination counter, 6 to 15 unmapped.

Top module: `dma_irq_ctrl`

## Requirements
- R1: While reset is applied, and afterwards until the first access or event, the status is 0, the mask is 0xFFF, both counters are 0 and `irq` is low.
- R2: A high bit of `evt_flags` at a clock edge sets the status bit of the same position for bits 11 (paused), 10 (transfer done), 9 (write data error), 8 (read data error), 7 (destination descriptor read error), 6 (source descriptor read error) and 3 (byte count overflow). Bits 5, 4, 2, 1 and 0 of `evt_flags` have no effect.
- R3: Status bits stay set until software writes a 1 to that bit at index 0. A write there with a bit at 0 leaves that bit unchanged. If an event sets a bit in the same cycle that software clears it, the bit stays set.
- R4: A write to index 2 clears each mask bit whose write data bit is 1. A write to index 3 sets each mask bit whose write data bit is 1. A write to index 1 has no effect. Reads of index 2 and index 3 return 0.
- R5: `irq` is a register. In the cycle after each edge, it equals the OR over all bits of (status AND NOT mask) as that state stood before the edge.
- R6: A pulse on `src_desc_done` adds one to the source counter (index 4) and sets status bit 1. A pulse on `dst_desc_done` adds one to the destination counter (index 5) and sets status bit 2.
- R7: A read of a counter returns its value and clears the counter. If the counter also increments in that cycle, it holds 1 afterwards.
- R8: An increment of a counter that holds 255 makes it 0 and sets status bit 4 (source) or bit 5 (destination). No overflow is raised when a read of that counter happens in the same cycle.
- R9: Any read or write of index 6 to 15 sets status bit 0. Such a read returns 0, and such a write changes no other state.
- R10: Read data appears on `reg_rdata` in the cycle after the read and holds until the next read. Bits 31:12 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 4 | Word index of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_flags | input | 12 | Event pulses from the channel datapath |
| src_desc_done | input | 1 | Source descriptor with interrupt flag completed |
| dst_desc_done | input | 1 | Destination descriptor with interrupt flag completed |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `reg_sel`, `reg_wr`, `reg_addr` and `reg_wdata` are stable, known values at each clock edge, and that each access lasts exactly one cycle. They also assume that event and done inputs are single-cycle samples, not held handshakes. The bench drives every input on the falling edge for exactly one cycle per step. It draws addresses over the whole 4-bit index range, so unmapped indices come up often. It keeps event density low so that status bits both set and clear during the random phase.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int STAT_W = 12;

  // word indices of the register port
  localparam int unsigned IDX_STATUS  = 0;
  localparam int unsigned IDX_MASK    = 1;
  localparam int unsigned IDX_UNMASK  = 2;
  localparam int unsigned IDX_MASKSET = 3;
  localparam int unsigned IDX_SRC_CNT = 4;
  localparam int unsigned IDX_DST_CNT = 5;

  // internally raised status bits
  localparam int BIT_BAD_ACCESS = 0;
  localparam int BIT_SRC_DONE   = 1;
  localparam int BIT_DST_DONE   = 2;
  localparam int BIT_SRC_OVF    = 4;
  localparam int BIT_DST_OVF    = 5;

  // status bits taken straight from the datapath event inputs
  localparam logic [STAT_W-1:0] EXT_EVT_MASK = 12'hFC8;

  typedef struct packed {
    logic wr_status;
    logic wr_unmask;
    logic wr_maskset;
    logic rd_en;
    logic rd_src;
    logic rd_dst;
    logic bad_access;
  } dec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic [31:0] idx;

  always_comb begin
    idx            = 32'(addr);
    dec            = '0;
    dec.rd_en      = sel && !wr;
    dec.wr_status  = sel && wr && (idx == IDX_STATUS);
    dec.wr_unmask  = sel && wr && (idx == IDX_UNMASK);
    dec.wr_maskset = sel && wr && (idx == IDX_MASKSET);
    dec.rd_src     = sel && !wr && (idx == IDX_SRC_CNT);
    dec.rd_dst     = sel && !wr && (idx == IDX_DST_CNT);
    dec.bad_access = sel && (idx > IDX_DST_CNT);
  end
endmodule

// File: rtl/irq_acct_counter.sv
module irq_acct_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q, count_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = inc || clr;
    count_d = count_q;
    if (clr)      count_d = inc ? CNT_W'(1) : '0;
    else if (inc) count_d = count_q + CNT_W'(1);
    wrap    = inc && !clr && (count_q == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status
);
  logic [W-1:0] status_q, status_d;
  logic         upd_en;

  always_comb begin
    upd_en   = |set_vec || |clr_vec;
    // setting outranks clearing on the same bit
    status_d = (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= '0;
    else if (upd_en) status_q <= status_d;
  end

  assign status = status_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         do_unmask,
  input  logic         do_maskset,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q, mask_d;
  logic         upd_en;

  always_comb begin
    upd_en = do_unmask || do_maskset;
    mask_d = mask_q;
    if (do_unmask)  mask_d = mask_q & ~bits;
    if (do_maskset) mask_d = mask_q | bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '1;
    else if (upd_en) mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] evt_flags,
  input  logic              src_desc_done,
  input  logic              dst_desc_done,
  output logic              irq
);
  localparam int NSIDE = 2;

  logic              rst_n_i;
  dec_t              dec;
  logic [STAT_W-1:0] status_q, mask_q, set_vec, clr_vec;
  logic [NSIDE-1:0]  side_inc, side_clr, side_wrap;
  logic [CNT_W-1:0]  side_cnt [NSIDE];
  logic [CNT_W-1:0]  src_cnt, dst_cnt;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              irq_q, irq_d;
  logic [DATA_W-STAT_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = reg_wdata[DATA_W-1:STAT_W];

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(reg_sel), .wr(reg_wr), .addr(reg_addr), .dec(dec)
  );

  assign side_inc = {dst_desc_done, src_desc_done};
  assign side_clr = {dec.rd_dst, dec.rd_src};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    irq_acct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n_i),
      .inc(side_inc[s]), .clr(side_clr[s]),
      .count(side_cnt[s]), .wrap(side_wrap[s])
    );
  end

  assign src_cnt = side_cnt[0];
  assign dst_cnt = side_cnt[1];

  always_comb begin
    set_vec                 = evt_flags & EXT_EVT_MASK;
    set_vec[BIT_SRC_DONE]   = src_desc_done;
    set_vec[BIT_DST_DONE]   = dst_desc_done;
    set_vec[BIT_SRC_OVF]    = side_wrap[0];
    set_vec[BIT_DST_OVF]    = side_wrap[1];
    set_vec[BIT_BAD_ACCESS] = dec.bad_access;
    clr_vec = dec.wr_status ? reg_wdata[STAT_W-1:0] : '0;
  end

  irq_status_reg #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n_i),
    .set_vec(set_vec), .clr_vec(clr_vec), .status(status_q)
  );

  irq_mask_reg #(.W(STAT_W)) u_mask (
    .clk(clk), .rst_n(rst_n_i),
    .do_unmask(dec.wr_unmask), .do_maskset(dec.wr_maskset),
    .bits(reg_wdata[STAT_W-1:0]), .mask(mask_q)
  );

  // read path: pre-edge state, registered
  always_comb begin
    rd_mux = '0;
    if (dec.rd_en) begin
      unique case (32'(reg_addr))
        IDX_STATUS:  rd_mux = DATA_W'(status_q);
        IDX_MASK:    rd_mux = DATA_W'(mask_q);
        IDX_SRC_CNT: rd_mux = DATA_W'(src_cnt);
        IDX_DST_CNT: rd_mux = DATA_W'(dst_cnt);
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)        rdata_q <= '0;
    else if (dec.rd_en)  rdata_q <= rd_mux;
  end

  always_comb irq_d = |(status_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q,
  input logic [CNT_W-1:0]  src_cnt
);
  logic [STAT_W-1:0] sw_clr;
  logic [31:0]       idx;

  always_comb begin
    idx    = 32'(reg_addr);
    sw_clr = (reg_sel && reg_wr && idx == IDX_STATUS) ? reg_wdata[STAT_W-1:0] : '0;
  end

  // R5: interrupt is the registered OR of unmasked pending bits
  a_r5_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(status_q & ~mask_q)));

  // R3: a set bit survives unless software wrote 1 to it
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & $past(status_q & ~sw_clr)) == $past(status_q & ~sw_clr));

  // R4: mask moves only on strobe writes
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && reg_wr && (idx == IDX_UNMASK || idx == IDX_MASKSET))
    |=> $stable(mask_q));

  // R9: unmapped access flags bit 0
  a_r9_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && idx > IDX_DST_CNT) |=> status_q[BIT_BAD_ACCESS]);

  // R7: a counter read leaves at most one count behind
  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr && idx == IDX_SRC_CNT) |=> (src_cnt <= CNT_W'(1)));

  // R10: upper read data bits stay zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:STAT_W] == '0);
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq(irq), .status_q(status_q), .mask_q(mask_q), .src_cnt(src_cnt)
);

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] evt_flags = '0;
  logic        src_desc_done = 1'b0, dst_desc_done = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [11:0] m_stat, m_mask;
  logic [7:0]  m_src, m_dst;

  always #10 clk = ~clk;

  dma_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_flags(evt_flags), .src_desc_done(src_desc_done),
    .dst_desc_done(dst_desc_done), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return {20'd0, m_stat};
      4'd1: return {20'd0, m_mask};
      4'd4: return {24'd0, m_src};
      4'd5: return {24'd0, m_dst};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R3";
      4'd1, 4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R7";
      default: return "R9";
    endcase
  endfunction

  // one access/event cycle; called at a falling edge
  task automatic step(input string tag, input bit sel, input bit wr, input logic [3:0] a,
                      input logic [31:0] wd, input logic [11:0] ev, input bit sd, input bit dd);
    logic [31:0] e_rd;
    logic        e_irq;
    logic [11:0] setv, clrv;
    bit          rs, rdd;
    reg_sel = sel; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    evt_flags = ev; src_desc_done = sd; dst_desc_done = dd;
    @(posedge clk);
    e_rd  = exp_read(a);
    e_irq = |(m_stat & ~m_mask);
    rs    = sel && !wr && a == 4'd4;
    rdd   = sel && !wr && a == 4'd5;
    setv  = ev & 12'hFC8;
    if (sd) setv[1] = 1'b1;
    if (dd) setv[2] = 1'b1;
    if (sd && !rs && m_src == 8'hFF) setv[4] = 1'b1;
    if (dd && !rdd && m_dst == 8'hFF) setv[5] = 1'b1;
    if (sel && a > 4'd5) setv[0] = 1'b1;
    clrv  = (sel && wr && a == 4'd0) ? wd[11:0] : 12'd0;
    m_stat = (m_stat & ~clrv) | setv;
    if (sel && wr && a == 4'd2) m_mask = m_mask & ~wd[11:0];
    if (sel && wr && a == 4'd3) m_mask = m_mask | wd[11:0];
    m_src = rs ? {7'd0, sd} : m_src + {7'd0, sd};
    m_dst = rdd ? {7'd0, dd} : m_dst + {7'd0, dd};
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; evt_flags = '0;
    src_desc_done = 1'b0; dst_desc_done = 1'b0;
    check("R5 irq", {31'd0, irq}, {31'd0, e_irq});
    if (sel && !wr) check(tag, reg_rdata, e_rd);
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    step(tag, 1'b1, 1'b0, a, 32'd0, 12'd0, 1'b0, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [3:0] a, input logic [31:0] d);
    step(tag, 1'b1, 1'b1, a, d, 12'd0, 1'b0, 1'b0);
  endtask

  task automatic idle(input string tag, input logic [11:0] ev, input bit sd, input bit dd);
    step(tag, 1'b0, 1'b0, 4'd0, 32'd0, ev, sd, dd);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_stat = '0; m_mask = 12'hFFF; m_src = '0; m_dst = '0;
    repeat (3) @(negedge clk);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    check("R1 reset rdata", reg_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values through reads
    rd("R1 status", 4'd0);
    rd("R1 mask", 4'd1);
    rd("R1 src count", 4'd4);
    rd("R1 dst count", 4'd5);

    // R2: external events, including the ignored positions
    idle("R2", 12'hFFF, 1'b0, 1'b0);
    rd("R2 event set", 4'd0);
    wr("R3 clear all", 4'd0, 32'hFFF);
    idle("R2", 12'h037, 1'b0, 1'b0);
    rd("R2 ignored bits", 4'd0);

    // R4: mask strobes, direct write ignored, strobes read zero
    wr("R4", 4'd2, 32'h0000_0408);
    rd("R4 unmask", 4'd1);
    wr("R4", 4'd1, 32'h0000_0000);
    rd("R4 direct write ignored", 4'd1);
    wr("R4", 4'd3, 32'h0000_0008);
    rd("R4 maskset", 4'd1);
    rd("R4 unmask reads zero", 4'd2);
    rd("R4 maskset reads zero", 4'd3);

    // R5: interrupt rises and falls with an unmasked bit
    idle("R5", 12'h400, 1'b0, 1'b0);
    idle("R5", 12'h000, 1'b0, 1'b0);
    wr("R5", 4'd0, 32'h400);
    idle("R5", 12'h000, 1'b0, 1'b0);
    idle("R5", 12'h000, 1'b0, 1'b0);

    // R3: set beats clear in the same cycle
    step("R3", 1'b1, 1'b1, 4'd0, 32'h200, 12'h200, 1'b0, 1'b0);
    rd("R3 set wins", 4'd0);
    wr("R3 partial", 4'd0, 32'h000);
    rd("R3 zero write keeps", 4'd0);
    wr("R3", 4'd0, 32'hFFF);

    // R6: done pulses count and flag
    idle("R6", 12'd0, 1'b1, 1'b0);
    idle("R6", 12'd0, 1'b1, 1'b1);
    rd("R6 status", 4'd0);
    rd("R6 src count", 4'd4);
    rd("R6 dst count", 4'd5);

    // R7: read clear racing an increment
    idle("R7", 12'd0, 1'b1, 1'b0);
    step("R7 read+inc", 1'b1, 1'b0, 4'd4, 32'd0, 12'd0, 1'b1, 1'b0);
    rd("R7 left one", 4'd4);
    wr("R7", 4'd0, 32'hFFF);

    // R8: wrap of both counters
    for (int i = 0; i < 256; i++) idle("R8", 12'd0, 1'b1, 1'b1);
    rd("R8 overflow bits", 4'd0);
    rd("R8 src wrapped", 4'd4);
    rd("R8 dst wrapped", 4'd5);
    wr("R8", 4'd0, 32'hFFF);
    for (int i = 0; i < 255; i++) idle("R8", 12'd0, 1'b1, 1'b0);
    step("R8 read at 255", 1'b1, 1'b0, 4'd4, 32'd0, 12'd0, 1'b1, 1'b0);
    rd("R8 no overflow on read", 4'd0);

    // R9: unmapped accesses
    wr("R9", 4'd0, 32'hFFF);
    wr("R9", 4'd9, 32'hFFFF_FFFF);
    rd("R9 mask untouched", 4'd1);
    rd("R9 read zero", 4'd15);
    rd("R9 flag", 4'd0);

    // R10: held read data with zero upper bits
    wr("R10", 4'd3, 32'hFFFF_FFFF);
    rd("R10 upper zero", 4'd1);
    idle("R10", 12'd0, 1'b0, 1'b0);
    check("R10 hold", reg_rdata, 32'h0000_0FFF);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      bit          s, w;
      a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) a = 4'($urandom_range(0, 5));
      d = $urandom;
      s = ($urandom_range(0, 2) != 0);
      w = $urandom_range(0, 1) == 1;
      step(tag_of(a), s, w, a, d, 12'($urandom & $urandom & $urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
    end
    for (int a = 0; a < 6; a++) rd(tag_of(4'(a)), 4'(a));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule